// File: doc/BRIEF.md
# Byte FIFO with Sticky Status Flags and Interrupt

This block is a byte-wide support buffer that sits beside a serial data path. A byte write port fills it and a byte read port drains it. Software reaches a small register port through which it sets the data direction and a target fill level. It also enables interrupt sources, clears status bits, and may move the read or write pointer directly.

Three sticky flags record what happened: overflow, underflow and fill-level-reached. The fill level is the write pointer minus the read pointer. Both pointers carry one wrap bit above the address bits. Overflow is raised by a write to a full buffer, and also whenever a pointer written by software leaves the level above the depth. The fill-level flag is tested after each accepted write when the direction is receive, or after each accepted read when the direction is transmit. A level interrupt line is the OR of the set flags whose enable is on.

Register map on `reg_addr`:
- 0: status. Bit 2 is overflow, bit 1 is underflow and bit 0 is fill-level-reached. Writing 1 to a bit clears it.
- 1: config. Bit 7 is the direction, 0 for receive and 1 for transmit. Bits 4:0 hold the target level.
- 2: interrupt enable. Bit 0 enables the level source and bit 1 enables the error source.
- 3: read pointer.
- 4: write pointer.
- 5: current fill level, read only.

Top module: `bfifo_status_top`

## Requirements
- R1: After reset the status register reads 0x00, the fill level reads 0, `rd_data` is 0x00 and `irq` is low.
- R2: Status bits 7 to 3 always read 0, and writing 1s to them has no effect.
- R3: A write while the level is 16 or more discards the byte and leaves the level unchanged. Status bit 2 (overflow) is then set at the next clock edge.
- R4: If pointer writes make the level (write pointer minus read pointer, modulo 32) greater than 16, status bit 2 becomes set.
- R5: A read while the buffer is empty returns 0x00 on `rd_data` and leaves the level at 0. Status bit 1 (underflow) is set.
- R6: Bytes leave in the order they were accepted. Each appears on `rd_data` one clock edge after the cycle in which `rd_en` was high.
- R7: With config bit 7 at 0, status bit 0 becomes set after an accepted write that leaves the level equal to config bits 4:0.
- R8: With config bit 7 at 1, status bit 0 is set only after an accepted read that leaves the level equal to the target. Writes do not set it.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: A pulse on `irq_ack_err` clears status bits 2 and 1. A pulse on `irq_ack_lvl` clears status bit 0.
- R11: If a flag's set event and a clear of that flag happen in the same cycle, the flag ends up set.
- R12: `irq` is high exactly when status bit 0 is set with enable bit 0 on, or when status bit 2 or bit 1 is set with enable bit 1 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one byte this cycle |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read one byte this cycle |
| rd_data | output | 8 | Byte read, valid one edge after `rd_en` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_ack_err | input | 1 | Acknowledge of the error interrupt |
| irq_ack_lvl | input | 1 | Acknowledge of the fill-level interrupt |
| irq | output | 1 | Interrupt request, level |

## Verification
Read data is due one clock edge after the cycle in which `rd_en` is high. Each flag, and the `irq` that follows from it, shows up one edge after the event that sets it. The one exception is overflow caused by a pointer write: it takes two edges, one to load the pointer and one to see the new level. Inputs are driven at falling edges and held for one full cycle. The scoreboard monitor compares read data at the falling edge after the rising edge that captured the read. Status and `irq` are sampled at least one falling edge after the stimulus is released, which is after the edge by which each result is due.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
   typedef enum logic [2:0] {
      RA_STATUS = 3'd0,
      RA_CONFIG = 3'd1,
      RA_IRQEN  = 3'd2,
      RA_RDPTR  = 3'd3,
      RA_WRPTR  = 3'd4,
      RA_LEVEL  = 3'd5
   } reg_addr_e;

   localparam int FLG_LVL = 0;
   localparam int FLG_UNF = 1;
   localparam int FLG_OVF = 2;
   localparam int NFLAGS  = 3;
   localparam int REG_W   = 8;
endpackage

// File: rtl/bfifo_store.sv
module bfifo_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              set_rptr,
   input  logic              set_wptr,
   input  logic [PW-1:0]     ptr_wdata,
   output logic [PW-1:0]     rptr,
   output logic [PW-1:0]     wptr,
   output logic [PW-1:0]     level,
   output logic [PW-1:0]     next_level,
   output logic              full,
   output logic              empty,
   output logic              wr_ok,
   output logic              rd_ok
);
   localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wptr_q, rptr_q, wptr_n, rptr_n;

   assign level = wptr_q - rptr_q;
   assign full  = (level >= DEPTH_L);
   assign empty = (level == '0);
   assign wr_ok = wr_en & ~full;
   assign rd_ok = rd_en & ~empty;

   always_comb begin
      wptr_n = wptr_q;
      rptr_n = rptr_q;
      if (set_wptr)   wptr_n = ptr_wdata;
      else if (wr_ok) wptr_n = wptr_q + PW'(1);
      if (set_rptr)   rptr_n = ptr_wdata;
      else if (rd_ok) rptr_n = rptr_q + PW'(1);
   end

   assign next_level = wptr_n - rptr_n;
   assign rptr = rptr_q;
   assign wptr = wptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         rd_data <= '0;
      end else begin
         wptr_q <= wptr_n;
         rptr_q <= rptr_n;
         if (rd_en) rd_data <= rd_ok ? mem[rptr_q[AW-1:0]] : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr_q[AW-1:0]] <= wr_data;
   end

   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !set_wptr) |=> $stable(wptr_q)); // R3
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty && !set_rptr) |=> ($stable(rptr_q) && rd_data == '0)); // R5
endmodule

// File: rtl/bfifo_flags.sv
module bfifo_flags
   import bfifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PW   = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              wr_ok,
   input  logic              rd_ok,
   input  logic              full,
   input  logic              empty,
   input  logic [PW-1:0]     level,
   input  logic [PW-1:0]     next_level,
   input  logic              dir_tx,
   input  logic [PW-1:0]     target,
   input  logic [NFLAGS-1:0] clr_mask,
   input  logic              ack_err,
   input  logic              ack_lvl,
   input  logic              en_err,
   input  logic              en_lvl,
   output logic [NFLAGS-1:0] flags,
   output logic              irq
);
   localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH);

   logic [NFLAGS-1:0] set_ev, clr_ev;
   logic              moved;

   assign moved = dir_tx ? rd_ok : wr_ok;

   assign set_ev[FLG_OVF] = (wr_en & full) | (level > DEPTH_L);
   assign set_ev[FLG_UNF] = rd_en & empty;
   assign set_ev[FLG_LVL] = moved & (next_level == target);

   assign clr_ev[FLG_OVF] = clr_mask[FLG_OVF] | ack_err;
   assign clr_ev[FLG_UNF] = clr_mask[FLG_UNF] | ack_err;
   assign clr_ev[FLG_LVL] = clr_mask[FLG_LVL] | ack_lvl;

   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= set_ev[i] | (flags[i] & ~clr_ev[i]);
      end
   end

   assign irq = (flags[FLG_LVL] & en_lvl) |
                ((flags[FLG_OVF] | flags[FLG_UNF]) & en_err);

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[FLG_OVF] |=> flags[FLG_OVF]); // R3
   AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[FLG_UNF] |=> flags[FLG_UNF]); // R11
   AST_LVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[FLG_LVL] |=> flags[FLG_LVL]); // R7
   AST_LVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ev[FLG_LVL] && !set_ev[FLG_LVL]) |=> !flags[FLG_LVL]); // R9
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !irq); // R12
endmodule

// File: rtl/bfifo_regs.sv
module bfifo_regs
   import bfifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PW   = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NFLAGS-1:0] flags,
   input  logic [PW-1:0]     level,
   input  logic [PW-1:0]     rptr,
   input  logic [PW-1:0]     wptr,
   output logic              dir_tx,
   output logic [PW-1:0]     target,
   output logic              en_err,
   output logic              en_lvl,
   output logic [NFLAGS-1:0] clr_mask,
   output logic              set_rptr,
   output logic              set_wptr,
   output logic [PW-1:0]     ptr_wdata
);
   reg_addr_e  addr;
   logic       unused_wbits;
   logic [REG_W-1:0] cfg_view;

   assign addr = reg_addr_e'(reg_addr);
   assign unused_wbits = ^reg_wdata[REG_W-2:PW];

   assign clr_mask  = (reg_wr && addr == RA_STATUS) ? reg_wdata[NFLAGS-1:0] : '0;
   assign set_rptr  = reg_wr && addr == RA_RDPTR;
   assign set_wptr  = reg_wr && addr == RA_WRPTR;
   assign ptr_wdata = reg_wdata[PW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_tx <= 1'b0;
         target <= '0;
         en_err <= 1'b0;
         en_lvl <= 1'b0;
      end else if (reg_wr) begin
         if (addr == RA_CONFIG) begin
            dir_tx <= reg_wdata[REG_W-1];
            target <= reg_wdata[PW-1:0];
         end
         if (addr == RA_IRQEN) begin
            en_lvl <= reg_wdata[0];
            en_err <= reg_wdata[1];
         end
      end
   end

   always_comb begin
      cfg_view = '0;
      cfg_view[REG_W-1] = dir_tx;
      cfg_view[PW-1:0]  = target;
   end

   always_comb begin
      case (addr)
         RA_STATUS: reg_rdata = REG_W'(flags);
         RA_CONFIG: reg_rdata = cfg_view;
         RA_IRQEN:  reg_rdata = {{(REG_W-2){1'b0}}, en_err, en_lvl};
         RA_RDPTR:  reg_rdata = REG_W'(rptr);
         RA_WRPTR:  reg_rdata = REG_W'(wptr);
         RA_LEVEL:  reg_rdata = REG_W'(level);
         default:   reg_rdata = '0;
      endcase
   end

   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && addr == RA_CONFIG) |=> ($stable(dir_tx) && $stable(target))); // R8
endmodule

// File: rtl/bfifo_status_top.sv
module bfifo_status_top
   import bfifo_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              irq_ack_err,
   input  logic              irq_ack_lvl,
   output logic              irq
);
   localparam int PW = $clog2(DEPTH) + 1;

   if (DEPTH < 2 || DEPTH > 32 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two from 2 to 32");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic [PW-1:0]     rptr, wptr, level, next_level, target, ptr_wdata;
   logic              full, empty, wr_ok, rd_ok;
   logic              set_rptr, set_wptr, dir_tx, en_err, en_lvl;
   logic [NFLAGS-1:0] flags, clr_mask;

   bfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .set_rptr(set_rptr), .set_wptr(set_wptr), .ptr_wdata(ptr_wdata),
      .rptr(rptr), .wptr(wptr), .level(level), .next_level(next_level),
      .full(full), .empty(empty), .wr_ok(wr_ok), .rd_ok(rd_ok)
   );

   bfifo_flags #(.DEPTH(DEPTH)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .rd_en(rd_en), .wr_ok(wr_ok), .rd_ok(rd_ok),
      .full(full), .empty(empty), .level(level), .next_level(next_level),
      .dir_tx(dir_tx), .target(target), .clr_mask(clr_mask),
      .ack_err(irq_ack_err), .ack_lvl(irq_ack_lvl),
      .en_err(en_err), .en_lvl(en_lvl), .flags(flags), .irq(irq)
   );

   bfifo_regs #(.DEPTH(DEPTH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .flags(flags), .level(level),
      .rptr(rptr), .wptr(wptr), .dir_tx(dir_tx), .target(target),
      .en_err(en_err), .en_lvl(en_lvl), .clr_mask(clr_mask),
      .set_rptr(set_rptr), .set_wptr(set_wptr), .ptr_wdata(ptr_wdata)
   );
endmodule

// File: tb/bfifo_status_top_tb_top.sv
module bfifo_status_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, reg_wr = 1'b0;
   logic [7:0] wr_data = '0, reg_wdata = '0;
   logic [2:0] reg_addr = '0;
   logic       irq_ack_err = 1'b0, irq_ack_lvl = 1'b0;
   logic [7:0] rd_data, reg_rdata;
   logic       irq;

   int tests = 0;
   int fails = 0;
   int model_cnt = 0;
   logic [7:0] model_q[$];
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       mon_pend = 1'b0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   bfifo_status_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_ack_err(irq_ack_err), .irq_ack_lvl(irq_ack_lvl), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      if (model_cnt < 16) begin
         model_q.push_back(d);
         model_cnt++;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_read(input string tag);
      if (model_cnt > 0) begin
         exp_q.push_back(model_q.pop_front());
         model_cnt--;
      end else begin
         exp_q.push_back(8'h00);
      end
      tag_q.push_back(tag);
   endtask

   task automatic pop(input string tag);
      @(negedge clk);
      rd_en = 1'b1;
      expect_read(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // monitor: rd_data is due one edge after the rd_en cycle
   always @(posedge clk) mon_pend <= rd_en;
   always @(negedge clk) begin
      if (mon_pend) begin
         if (exp_q.size() == 0) chk("R6 unexpected read", rd_data, 8'hxx);
         else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(3'd0, rv); chk("R1 status", rv, 8'h00);
      reg_read(3'd5, rv); chk("R1 level", rv, 8'h00);
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);

      reg_write(3'd0, 8'hFF);
      reg_read(3'd0, rv); chk("R2 reserved", rv, 8'h00);

      push(8'h5A); push(8'hC3); push(8'h01);
      pop("R6 order"); pop("R6 order"); pop("R6 order");

      pop("R5 empty data");
      reg_read(3'd5, rv); chk("R5 level", rv, 8'h00);
      reg_read(3'd0, rv); chk("R5 underflow", rv, 8'h02);
      reg_write(3'd0, 8'h00);
      reg_read(3'd0, rv); chk("R9 write zero", rv, 8'h02);
      reg_write(3'd0, 8'h02);
      reg_read(3'd0, rv); chk("R9 write one", rv, 8'h00);

      reg_write(3'd2, 8'h02);
      pop("R5 empty data");
      chk("R12 irq err", {7'd0, irq}, 8'h01);
      @(negedge clk); irq_ack_err = 1'b1;
      @(negedge clk); irq_ack_err = 1'b0;
      reg_read(3'd0, rv); chk("R10 ack err", rv, 8'h00);
      chk("R12 irq low", {7'd0, irq}, 8'h00);

      for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
      reg_read(3'd0, rv); chk("R3 no flag when exactly full", rv, 8'h00);
      push(8'hAA);
      reg_read(3'd5, rv); chk("R3 level held", rv, 8'h10);
      reg_read(3'd0, rv); chk("R3 overflow", rv, 8'h04);
      for (int i = 0; i < 16; i++) pop("R3 R6 drain");
      reg_write(3'd0, 8'h07);
      reg_write(3'd2, 8'h00);

      reg_write(3'd1, 8'h03);
      push(8'h21); push(8'h22);
      reg_read(3'd0, rv); chk("R7 before target", rv, 8'h00);
      push(8'h23);
      reg_read(3'd0, rv); chk("R7 target hit", rv, 8'h01);
      reg_write(3'd2, 8'h01);
      chk("R12 irq lvl", {7'd0, irq}, 8'h01);
      @(negedge clk); irq_ack_lvl = 1'b1;
      @(negedge clk); irq_ack_lvl = 1'b0;
      reg_read(3'd0, rv); chk("R10 ack lvl", rv, 8'h00);

      reg_write(3'd1, 8'h84);
      push(8'h24);
      reg_read(3'd0, rv); chk("R8 write ignored", rv, 8'h00);
      reg_write(3'd1, 8'h82);
      pop("R8 data");
      reg_read(3'd0, rv); chk("R8 level 3", rv, 8'h00);
      pop("R8 data");
      reg_read(3'd0, rv); chk("R8 target hit", rv, 8'h01);
      pop("R8 data"); pop("R8 data");
      reg_write(3'd0, 8'h01);
      reg_write(3'd2, 8'h00);
      reg_write(3'd1, 8'h00);

      pop("R5 empty data");
      @(negedge clk);
      rd_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h02;
      expect_read("R5 empty data");
      @(negedge clk);
      rd_en = 1'b0; reg_wr = 1'b0;
      reg_read(3'd0, rv); chk("R11 set wins", rv, 8'h02);
      reg_write(3'd0, 8'h02);

      reg_write(3'd3, 8'h00);
      reg_write(3'd4, 8'h14);
      @(negedge clk);
      reg_read(3'd5, rv); chk("R4 level", rv, 8'h14);
      reg_read(3'd0, rv); chk("R4 overflow", rv, 8'h04);
      reg_write(3'd4, 8'h00);
      reg_write(3'd0, 8'h04);
      reg_read(3'd0, rv); chk("R4 cleared", rv, 8'h00);

      repeat (3) @(negedge clk);
      summary();
   end
endmodule